// File: doc/BRIEF.md
# Triple-Redundant Result Voter with Median Select

This block sits behind three identical processor cores that execute the same program in lock-step. Each vote cycle it takes one result word from each core and produces a single registered output word plus status. In exact mode it looks for a two-of-three agreement at word level, so one bad core is hidden from the rest of the system, and it names the core that disagreed. In median mode, meant for converter readings whose low bits can differ between healthy cores, it forwards the unsigned middle value of the three.

The block also keeps track of core health. A core named as the outlier on several exact votes in a row is retired and ignored from then on. With two cores left the block works as a plain comparator. If that pair keeps disagreeing, both are retired and the output goes silent. A two-bit level output reports how far the system has degraded.

Top module: `tmr_voter`

## Requirements
- R1: In exact mode with three healthy cores, if all three words are equal, the next cycle shows `out_valid`=1, `out_data` equal to that word, `outlier`=0 and `disagree`=0.
- R2: In exact mode with three healthy cores, if exactly one word differs from the other two, the output is the common word with `out_valid`=1. `outlier` is one-hot on the differing core (bit 0 = A, bit 1 = B, bit 2 = C).
- R3: In exact mode with three healthy cores, if all three words differ, the next cycle shows `disagree`=1, `out_valid`=0 and `outlier`=0.
- R4: In median mode (`mode_mid`=1) with three healthy cores, the output is the unsigned median of the three words (ties included), with `out_valid`=1 and no outlier flag.
- R5: Each core has a count of consecutive exact votes (three healthy cores) on which it was the outlier. An exact vote that does not flag it clears the count. Median votes and idle cycles leave the count unchanged. When the count reaches FAIL_LIMIT, the core's `healthy` bit clears on that same edge.
- R6: With two healthy cores in exact mode, the output is their common word (valid) if they are equal; otherwise `disagree`=1 and `out_valid`=0. The retired core's input has no effect.
- R7: With two healthy cores in median mode, the output is the unsigned smaller of the two healthy words, with `out_valid`=1.
- R8: FAIL_LIMIT consecutive pair mismatches in exact mode clear every `healthy` bit. With fewer than two healthy cores, no vote ever produces `out_valid`=1.
- R9: `level` is 0 (fail-operational) with three healthy cores, 1 (fail-safe) with two, and 2 (fail-silent) with one or none.
- R10: Outputs follow the sampled inputs by one clock. A cycle with `in_valid`=0 yields `out_valid`=0, `outlier`=0 and `disagree`=0 on the next cycle.
- R11: Synchronous reset sets `healthy`=3'b111, `level`=0, `out_valid`=0, `out_data`=0, `outlier`=0 and `disagree`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A vote is presented this cycle |
| mode_mid | input | 1 | 1 = median select, 0 = exact vote |
| ch_a | input | DATA_W | Result word of core A |
| ch_b | input | DATA_W | Result word of core B |
| ch_c | input | DATA_W | Result word of core C |
| out_valid | output | 1 | Output word is trustworthy |
| out_data | output | DATA_W | Voted or selected word |
| outlier | output | 3 | One-hot flag of the disagreeing core |
| disagree | output | 1 | No majority (three cores) or pair mismatch (two cores) |
| healthy | output | 3 | Per-core health, bit 0 = A |
| level | output | 2 | Degradation level: 0 operational, 1 safe, 2 silent |

## Verification
The hardest state to reach from the ports is fail-silent. Reaching it takes an unbroken run of FAIL_LIMIT outlier votes against one core, and then an unbroken run of pair mismatches among the two survivors. Directed sequences build both runs on purpose. They slip median votes into the first run to show that such votes do not break it, and insert an agreeing pair vote to show that it does clear the mismatch count. After a reset, random traffic corrupts single words at a moderate rate, so retirement also happens at random points while median and idle cycles are interleaved.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    LVL_OPER   = 2'd0,
    LVL_SAFE   = 2'd1,
    LVL_SILENT = 2'd2
  } lvl_e;
endpackage

// File: rtl/tmr_exact_vote.sv
module tmr_exact_vote #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] word,
  output logic [2:0]        odd_one,
  output logic              majority
);
  logic eq_ab, eq_ac, eq_bc;

  assign eq_ab = (a == b);
  assign eq_ac = (a == c);
  assign eq_bc = (b == c);

  always_comb begin
    word     = a;
    odd_one  = 3'b000;
    majority = 1'b1;
    if (eq_ab && eq_ac) begin
      odd_one = 3'b000;
    end else if (eq_ab) begin
      odd_one = 3'b100;
    end else if (eq_ac) begin
      odd_one = 3'b010;
    end else if (eq_bc) begin
      word    = b;
      odd_one = 3'b001;
    end else begin
      majority = 1'b0;
    end
  end
endmodule

// File: rtl/tmr_median.sv
module tmr_median #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] mid
);
  logic ge_ab, ge_ac, ge_bc;

  assign ge_ab = (a >= b);
  assign ge_ac = (a >= c);
  assign ge_bc = (b >= c);

  always_comb begin
    if (ge_ab ^ ge_ac)  mid = a;
    else if (ge_ab)     mid = ge_bc ? b : c;
    else                mid = ge_bc ? c : b;
  end
endmodule

// File: rtl/tmr_health.sv
module tmr_health
  import tmr_pkg::*;
#(
  parameter int FAIL_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vote3_en,
  input  logic [2:0] odd_one,
  input  logic       pair_en,
  input  logic       pair_mis,
  output logic [2:0] healthy,
  output logic [1:0] level
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FAIL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q [3];
  logic [CNT_W-1:0] cnt_d [3];
  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic [2:0]       h_q, h_d;
  lvl_e             lvl_q, lvl_d;

  always_comb begin
    h_d    = h_q;
    pcnt_d = pcnt_q;
    for (int i = 0; i < 3; i++) begin
      cnt_d[i] = cnt_q[i];
      if (vote3_en) begin
        if (odd_one[i]) begin
          cnt_d[i] = cnt_q[i] + 1'b1;
          if (cnt_q[i] == LAST) h_d[i] = 1'b0;
        end else begin
          cnt_d[i] = '0;
        end
      end
    end
    if (pair_en) begin
      if (pair_mis) begin
        pcnt_d = pcnt_q + 1'b1;
        if (pcnt_q == LAST) h_d = 3'b000;
      end else begin
        pcnt_d = '0;
      end
    end
    case ($countones(h_d))
      3:       lvl_d = LVL_OPER;
      2:       lvl_d = LVL_SAFE;
      default: lvl_d = LVL_SILENT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q    <= 3'b111;
      pcnt_q <= '0;
      lvl_q  <= LVL_OPER;
      for (int i = 0; i < 3; i++) cnt_q[i] <= '0;
    end else begin
      h_q    <= h_d;
      pcnt_q <= pcnt_d;
      lvl_q  <= lvl_d;
      for (int i = 0; i < 3; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  assign healthy = h_q;
  assign level   = lvl_q;
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int DATA_W     = 16,
  parameter int FAIL_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode_mid,
  input  logic [DATA_W-1:0] ch_a,
  input  logic [DATA_W-1:0] ch_b,
  input  logic [DATA_W-1:0] ch_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [2:0]        outlier,
  output logic              disagree,
  output logic [2:0]        healthy,
  output logic [1:0]        level
);
  logic [DATA_W-1:0] ex_word, med_word, px, py, nxt_data;
  logic [2:0]        ex_odd, nxt_odd;
  logic              ex_maj, three_ok, two_ok, pair_eq;
  logic              nxt_valid, nxt_dis;

  tmr_exact_vote #(.DATA_W(DATA_W)) u_exact (
    .a(ch_a), .b(ch_b), .c(ch_c),
    .word(ex_word), .odd_one(ex_odd), .majority(ex_maj)
  );

  tmr_median #(.DATA_W(DATA_W)) u_median (
    .a(ch_a), .b(ch_b), .c(ch_c), .mid(med_word)
  );

  assign three_ok = (healthy == 3'b111);
  assign two_ok   = ($countones(healthy) == 2);
  assign px       = healthy[0] ? ch_a : ch_b;
  assign py       = healthy[2] ? ch_c : ch_b;
  assign pair_eq  = (px == py);

  tmr_health #(.FAIL_LIMIT(FAIL_LIMIT)) u_health (
    .clk(clk), .rst(rst),
    .vote3_en(in_valid && !mode_mid && three_ok),
    .odd_one(ex_odd),
    .pair_en(in_valid && !mode_mid && two_ok),
    .pair_mis(!pair_eq),
    .healthy(healthy), .level(level)
  );

  always_comb begin
    nxt_valid = 1'b0;
    nxt_data  = '0;
    nxt_odd   = 3'b000;
    nxt_dis   = 1'b0;
    if (three_ok) begin
      if (mode_mid) begin
        nxt_valid = 1'b1;
        nxt_data  = med_word;
      end else begin
        nxt_valid = ex_maj;
        nxt_data  = ex_maj ? ex_word : '0;
        nxt_odd   = ex_odd;
        nxt_dis   = !ex_maj;
      end
    end else if (two_ok) begin
      if (mode_mid) begin
        nxt_valid = 1'b1;
        nxt_data  = (px < py) ? px : py;
      end else begin
        nxt_valid = pair_eq;
        nxt_data  = pair_eq ? px : '0;
        nxt_dis   = !pair_eq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      outlier   <= 3'b000;
      disagree  <= 1'b0;
    end else if (in_valid) begin
      out_valid <= nxt_valid;
      out_data  <= nxt_data;
      outlier   <= nxt_odd;
      disagree  <= nxt_dis;
    end else begin
      out_valid <= 1'b0;
      outlier   <= 3'b000;
      disagree  <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_voter_chk.sv
module tmr_voter_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       out_valid,
  input logic [2:0] outlier,
  input logic       disagree,
  input logic [2:0] healthy,
  input logic [1:0] level
);
  assert_outlier_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(outlier));

  assert_disagree_invalid_R3: assert property (@(posedge clk) disable iff (rst)
    disagree |-> !out_valid);

  assert_health_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    (healthy & ~$past(healthy)) == 3'b000);

  assert_silent_no_output_R8: assert property (@(posedge clk) disable iff (rst)
    (level == 2'd2) |-> !out_valid);

  assert_level_oper_R9: assert property (@(posedge clk) disable iff (rst)
    (($countones(healthy) == 3) == (level == 2'd0)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !disagree && outlier == 3'b000));
endmodule

bind tmr_voter tmr_voter_chk i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .outlier(outlier), .disagree(disagree), .healthy(healthy), .level(level)
);

// File: tb/test_tmr_voter.sv
module test_tmr_voter;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW  = 16;
  localparam int LIM = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          mode_mid = 1'b0;
  logic [DW-1:0] ch_a = '0, ch_b = '0, ch_c = '0;
  logic          out_valid, disagree;
  logic [DW-1:0] out_data;
  logic [2:0]    outlier, healthy;
  logic [1:0]    level;

  int checks = 0;
  int fails  = 0;

  logic [2:0] m_h;
  int         m_cnt [3];
  int         m_pc;

  always #2 clk = ~clk;

  tmr_voter #(.DATA_W(DW), .FAIL_LIMIT(LIM)) i_tmr_voter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_mid(mode_mid),
    .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c),
    .out_valid(out_valid), .out_data(out_data), .outlier(outlier),
    .disagree(disagree), .healthy(healthy), .level(level)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] med3(input logic [DW-1:0] a, b, c);
    logic [DW-1:0] t;
    if (a > b) begin t = a; a = b; b = t; end
    if (b > c) begin t = b; b = c; c = t; end
    if (a > b) begin t = a; a = b; b = t; end
    return b;
  endfunction

  function automatic logic [1:0] lvl_of(input logic [2:0] h);
    int n = $countones(h);
    return (n == 3) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
  endfunction

  task automatic model_reset();
    m_h = 3'b111;
    m_pc = 0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R11", "healthy", 32'(healthy), 32'h7);
    chk("R11", "level", 32'(level), 32'h0);
    chk("R11", "out_valid", 32'(out_valid), 32'h0);
    chk("R11", "out_data", 32'(out_data), 32'h0);
    chk("R11", "flags", {28'h0, disagree, outlier}, 32'h0);
  endtask

  task automatic vote(input string tag, input logic mid,
                      input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [DW-1:0] c);
    logic          e_v, e_d;
    logic [DW-1:0] e_w, x, y;
    logic [2:0]    e_o;
    int            n;
    e_v = 1'b0; e_d = 1'b0; e_w = '0; e_o = 3'b000;
    n = $countones(m_h);
    if (n == 3) begin
      if (mid) begin
        e_v = 1'b1; e_w = med3(a, b, c);
      end else begin
        if (a == b && a == c) begin e_v = 1'b1; e_w = a; end
        else if (a == b) begin e_v = 1'b1; e_w = a; e_o = 3'b100; end
        else if (a == c) begin e_v = 1'b1; e_w = a; e_o = 3'b010; end
        else if (b == c) begin e_v = 1'b1; e_w = b; e_o = 3'b001; end
        else e_d = 1'b1;
        for (int i = 0; i < 3; i++) begin
          if (e_o[i]) begin
            m_cnt[i]++;
            if (m_cnt[i] == LIM) m_h[i] = 1'b0;
          end else m_cnt[i] = 0;
        end
      end
    end else if (n == 2) begin
      x = m_h[0] ? a : b;
      y = m_h[2] ? c : b;
      if (mid) begin
        e_v = 1'b1; e_w = (x < y) ? x : y;
      end else if (x == y) begin
        e_v = 1'b1; e_w = x; m_pc = 0;
      end else begin
        e_d = 1'b1; m_pc++;
        if (m_pc == LIM) m_h = 3'b000;
      end
    end
    in_valid = 1'b1; mode_mid = mid; ch_a = a; ch_b = b; ch_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "out_valid", 32'(out_valid), 32'(e_v));
    if (e_v) chk(tag, "out_data", 32'(out_data), 32'(e_w));
    chk(tag, "outlier", 32'(outlier), 32'(e_o));
    chk(tag, "disagree", 32'(disagree), 32'(e_d));
    chk(tag, "healthy", 32'(healthy), 32'(m_h));
    chk(tag, "level", 32'(level), 32'(lvl_of(m_h)));
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0;
    ch_a = 16'h1234; ch_b = 16'h4321; ch_c = 16'h0F0F;
    @(negedge clk);
    chk(tag, "idle out_valid", 32'(out_valid), 32'h0);
    chk(tag, "idle flags", {28'h0, disagree, outlier}, 32'h0);
    chk(tag, "idle healthy", 32'(healthy), 32'(m_h));
  endtask

  initial begin
    #600000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] base, va, vb, vc;
    logic          md;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    vote("R1", 1'b0, 16'd10, 16'd10, 16'd10);
    vote("R1", 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    vote("R2", 1'b0, 16'd7, 16'd7, 16'd9);
    vote("R2", 1'b0, 16'd7, 16'd8, 16'd7);
    vote("R2", 1'b0, 16'd1, 16'd2, 16'd2);
    vote("R3", 1'b0, 16'd1, 16'd2, 16'd3);
    vote("R4", 1'b1, 16'd100, 16'd102, 16'd101);
    vote("R4", 1'b1, 16'd5, 16'd5, 16'd3);
    vote("R4", 1'b1, 16'hFFFF, 16'd0, 16'd1);
    idle("R10");
    // R5: median votes and idle cycles between outlier votes keep the run going
    vote("R5", 1'b0, 16'd4, 16'd4, 16'd0);
    vote("R5", 1'b1, 16'd4, 16'd4, 16'd9);
    idle("R5");
    vote("R5", 1'b0, 16'd4, 16'd4, 16'd1);
    vote("R5", 1'b0, 16'd4, 16'd4, 16'd2);
    chk("R9", "level after first retire", 32'(level), 32'h1);
    vote("R6", 1'b0, 16'd9, 16'd9, 16'd123);
    vote("R6", 1'b0, 16'd9, 16'd8, 16'd9);
    vote("R6", 1'b0, 16'd9, 16'd9, 16'd9);
    vote("R7", 1'b1, 16'd20, 16'd17, 16'd3);
    vote("R8", 1'b0, 16'd1, 16'd2, 16'd1);
    vote("R8", 1'b0, 16'd3, 16'd4, 16'd3);
    vote("R8", 1'b0, 16'd5, 16'd6, 16'd5);
    chk("R9", "level silent", 32'(level), 32'h2);
    vote("R8", 1'b0, 16'd5, 16'd5, 16'd5);
    vote("R8", 1'b1, 16'd5, 16'd5, 16'd5);

    do_reset();
    for (int k = 0; k < 1500; k++) begin
      if (($urandom % 10) == 0) begin
        idle("R10");
      end else begin
        base = DW'($urandom);
        md   = (($urandom % 3) == 0);
        if (md) begin
          va = base + DW'($urandom % 4);
          vb = base + DW'($urandom % 4);
          vc = base + DW'($urandom % 4);
        end else begin
          va = base; vb = base; vc = base;
          if (($urandom % 5) == 0) va = base ^ DW'(($urandom % 255) + 1);
          if (($urandom % 5) == 0) vb = base ^ DW'(($urandom % 255) + 1);
          if (($urandom % 4) == 0) vc = base ^ DW'(($urandom % 255) + 1);
        end
        vote("R2", md, va, vb, vc);
      end
      if ($countones(m_h) < 2 && ($urandom % 8) == 0) do_reset();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule